// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Frozen Read Copy

This block keeps the time of day and the calendar (seconds, minutes, hours, day of month, day of week, month and a two-digit year) as packed BCD counters that advance on a one-second tick. The tick is a single-cycle pulse from a prescaler upstream. Software sees the time through a small register port with a 4-bit address, 8-bit data, a select, a read enable and a write enable. The port shows a copy of the counters, not the counters themselves.

The copy is refreshed from the counters once per second. A freeze bit in the control register stops the refresh so that software can read a consistent snapshot or write a new time. The counters keep running while the copy is frozen. When software clears the freeze bit, the fields it wrote during the freeze are loaded into the counters. Fields it did not write keep their running count.

Hours count in either 12-hour or 24-hour form, selected by a control bit. Month length and leap years are handled automatically. A daylight-saving enable bit is stored and read back but changes nothing. Switching between 12-hour and 24-hour form does not convert the hours value; software rewrites the hours field after it changes the mode.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, the registers read seconds 00, minutes 00, hours 00, day of month 01, day of week 01, month 01, year 00 and control 0x02 (24-hour form).
- R2: While select and read enable are both high, rdata shows the addressed register in the same cycle; otherwise rdata is 0x00. The address map is: 0x0 seconds, 0x2 minutes, 0x4 hours, 0x6 day of month, 0x8 day of week, 0x9 month, 0xA year, 0xE control. Every other address reads 0x00.
- R3: A write is a period with select and write enable both high. It takes effect at the clock edge that first samples that pair inactive, using the address and data from the last active cycle. Writable bits are: seconds 0x7F, minutes 0x7F, hours 0xBF, day 0x3F, day of week 0x07, month 0x1F, year 0xFF, control 0x0B. All other bits read 0. Writes to unmapped addresses change nothing.
- R4: Each tick adds one second. Seconds and minutes count 00 to 59; 59 wraps to 00 and carries into the next field.
- R5: With control bit 1 set, hours count 00 to 23. Going from 23 to 00 advances the day of month and the day of week.
- R6: With control bit 1 clear, hours count 01 to 12 and bit 7 is the PM flag (1 = PM). 11 becomes 12 and toggles the flag, and 12 becomes 01. Going from 11 PM to 12 AM advances the day.
- R7: Day of week counts 1 to 7 and wraps from 7 to 1.
- R8: Months 04, 06, 09 and 11 have 30 days, and month 02 has 28 days. Month 02 has 29 days when the year value is divisible by 4 (00 counts as a leap year). All other months have 31 days. Day 01 follows the last day of the month.
- R9: Month 01 follows month 12 and increments the year. Year 99 rolls over to 00.
- R10: When a tick is sampled with the freeze bit clear, the counters change at that edge and the user copy takes the new values at the next edge.
- R11: While the freeze bit (control bit 3) is 1, the user copy is not refreshed and the counters keep running. A refresh whose tick was sampled before the freeze took effect still completes.
- R12: A control write that clears the freeze bit loads the fields written during the freeze into the counters at the following edge. The other fields keep counting, and refreshes resume at the next tick.
- R13: A time-register write while the freeze bit is 0 changes only the user copy. The next refresh overwrites it.
- R14: Control bit 0 is stored and read back and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| sel | input | 1 | Register port select |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |

## Verification
Each result has its own latency:
- Read data is combinational and is due in the cycle the address is presented.
- A write shows one edge after the strobe drops.
- A tick moves the counters at the sampling edge and the user copy one edge later.
- A freeze release reaches the counters one edge after the release write lands.

The bench keeps a behavioural model that steps once per rising edge using the inputs held over that cycle. It compares rdata against the model at every falling edge, so each of these latencies is checked in the exact cycle it is due. Some read strobes are placed directly behind a tick so that the one-cycle gap before the refresh is observed too.

// File: rtl/rtc_pkg.sv
// Shared constants, types and field tables for the BCD timekeeper.
// Assumes seven time fields, each one byte of packed BCD.
package rtc_pkg;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 7;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DATE = 3;
    localparam int F_DOW  = 4;
    localparam int F_MON  = 5;
    localparam int F_YR   = 6;

    typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] time_vec_t;

    localparam logic [ADDR_W-1:0] FIELD_ADDR [NUM_FIELDS] =
        '{4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9, 4'hA};
    localparam logic [DATA_W-1:0] FIELD_MASK [NUM_FIELDS] =
        '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h07, 8'h1F, 8'hFF};
    localparam logic [DATA_W-1:0] FIELD_RST  [NUM_FIELDS] =
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hE;
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'h0B;
    localparam logic [DATA_W-1:0] CTRL_RST  = 8'h02;
    localparam int CTRL_DST    = 0;
    localparam int CTRL_MODE24 = 1;
    localparam int CTRL_FREEZE = 3;
endpackage

// File: rtl/rtc_bus_port.sv
// Write strobe tracker: latches address and data while select and write
// enable are high, and issues a one-cycle commit when the pair drops.
// Assumes the inputs are synchronous to clk.
module rtc_bus_port #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic          act;
    logic          act_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign act = sel && wr_en;

    // Hold the strobe state and the last address/data seen while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= act;
            if (act) begin
                addr_q <= addr;
                data_q <= wdata;
            end
        end
    end

    // Commit in the cycle the strobe is first seen inactive.
    always_comb begin
        wr_commit = act_q && !act;
        wr_addr   = addr_q;
        wr_data   = data_q;
    end
endmodule

// File: rtl/rtc_calendar_step.sv
// Combinational next-second function for a packed BCD time vector.
// Assumes valid BCD input; invalid values step but are not corrected.
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  time_vec_t cur,
    input  logic      mode24,
    output time_vec_t nxt
);
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    logic       s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
    logic [5:0] hlow;
    logic       pm;
    logic [7:0] hinc;

    // Ripple the carry from seconds up to years.
    always_comb begin
        nxt     = cur;
        hlow    = cur[F_HR][5:0];
        pm      = cur[F_HR][7];
        hinc    = bcd_inc({2'b00, hlow});
        s_wrap  = (cur[F_SEC] == 8'h59);
        m_wrap  = s_wrap && (cur[F_MIN] == 8'h59);
        h_wrap  = 1'b0;
        nxt[F_SEC] = s_wrap ? 8'h00 : bcd_inc(cur[F_SEC]);
        if (s_wrap) begin
            nxt[F_MIN] = m_wrap ? 8'h00 : bcd_inc(cur[F_MIN]);
        end
        if (m_wrap) begin
            if (mode24) begin
                h_wrap     = (hlow == 6'h23);
                nxt[F_HR]  = h_wrap ? 8'h00 : {2'b00, hinc[5:0]};
            end else if (hlow == 6'h11) begin
                h_wrap     = pm;
                nxt[F_HR]  = {~pm, 7'h12};
            end else if (hlow == 6'h12) begin
                nxt[F_HR]  = {pm, 7'h01};
            end else begin
                nxt[F_HR]  = {pm, 1'b0, hinc[5:0]};
            end
        end
        d_wrap  = h_wrap && (cur[F_DATE] == last_day(cur[F_MON], cur[F_YR]));
        mo_wrap = d_wrap && (cur[F_MON] == 8'h12);
        if (h_wrap) begin
            nxt[F_DATE] = d_wrap ? 8'h01 : bcd_inc(cur[F_DATE]);
            nxt[F_DOW]  = (cur[F_DOW] == 8'h07) ? 8'h01 : cur[F_DOW] + 8'h01;
        end
        if (d_wrap) begin
            nxt[F_MON] = mo_wrap ? 8'h01 : bcd_inc(cur[F_MON]);
        end
        if (mo_wrap) begin
            nxt[F_YR] = (cur[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YR]);
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
// Top of the BCD timekeeper. Holds the running counters, the user-visible
// copy, the control register and the per-field written-while-frozen marks.
// Assumes tick_1hz is a single-cycle pulse synchronous to clk.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic                  wr_commit;
    logic [ADDR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]     wr_data;
    time_vec_t             cnt, cnt_base, cnt_step, usr;
    logic [DATA_W-1:0]     ctrl_q;
    logic [NUM_FIELDS-1:0] dirty;
    logic                  refresh_pend;
    logic                  load_pend;
    logic                  freeze;
    logic                  ctrl_hit;
    logic [DATA_W-1:0]     rd_val;
    logic [DATA_W-1:0]     usr_sec, cnt_sec, cnt_min;

    assign freeze   = ctrl_q[CTRL_FREEZE];
    assign ctrl_hit = wr_commit && (wr_addr == CTRL_ADDR);
    assign usr_sec  = usr[F_SEC];
    assign cnt_sec  = cnt[F_SEC];
    assign cnt_min  = cnt[F_MIN];

    rtc_bus_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    rtc_calendar_step u_step (
        .cur    (cnt_base),
        .mode24 (ctrl_q[CTRL_MODE24]),
        .nxt    (cnt_step)
    );

    // Control register, refresh request and freeze-release load request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= CTRL_RST;
            refresh_pend <= 1'b0;
            load_pend    <= 1'b0;
        end else begin
            refresh_pend <= tick_1hz && !freeze;
            load_pend    <= ctrl_hit && freeze && !wr_data[CTRL_FREEZE];
            if (ctrl_hit) begin
                ctrl_q <= wr_data & CTRL_MASK;
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            logic hit;
            assign hit = wr_commit && (wr_addr == FIELD_ADDR[i]);

            // Counter base: written value on release if marked, else running count.
            assign cnt_base[i] = (load_pend && dirty[i]) ? usr[i] : cnt[i];

            // User copy: a bus write wins over the periodic refresh.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    usr[i] <= FIELD_RST[i];
                end else if (hit) begin
                    usr[i] <= wr_data & FIELD_MASK[i];
                end else if (refresh_pend) begin
                    usr[i] <= cnt[i];
                end
            end

            // Mark fields written while frozen; clear them once loaded.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dirty[i] <= 1'b0;
                end else if (hit && freeze) begin
                    dirty[i] <= 1'b1;
                end else if (load_pend) begin
                    dirty[i] <= 1'b0;
                end
            end

            // Running counter: advance on tick from the (possibly loaded) base.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[i] <= FIELD_RST[i];
                end else begin
                    cnt[i] <= tick_1hz ? cnt_step[i] : cnt_base[i];
                end
            end
        end
    endgenerate

    // Read multiplexer, forced to zero when no read is active.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == FIELD_ADDR[i]) begin
                rd_val = usr[i];
            end
        end
        if (addr == CTRL_ADDR) begin
            rd_val = ctrl_q;
        end
        rdata = (sel && rd_en) ? rd_val : '0;
    end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
// Property checker for rtc_timekeeper, attached with bind below.
// Assumes synchronous active-low reset held for at least two edges.
module rtc_timekeeper_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_1hz,
    input logic          sel,
    input logic          rd_en,
    input logic [DW-1:0] rdata,
    input logic          freeze,
    input logic          refresh_pend,
    input logic          load_pend,
    input logic          wr_commit,
    input logic [DW-1:0] usr_sec,
    input logic [DW-1:0] cnt_sec,
    input logic [DW-1:0] cnt_min
);
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en) |-> rdata == '0); // R2

    AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_1hz) && !$past(load_pend)) |-> cnt_sec == $past(cnt_sec)); // R4

    AST_MIN_HOLD_BELOW_59: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_1hz) && $past(cnt_sec) != 8'h59 && !$past(load_pend))
        |-> cnt_min == $past(cnt_min)); // R4

    AST_REFRESH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && refresh_pend) |-> ($past(tick_1hz) && !$past(freeze))); // R10

    AST_FROZEN_COPY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && freeze && $past(freeze) && !$past(refresh_pend) && !$past(wr_commit))
        |-> $stable(usr_sec)); // R11

    AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && load_pend) |-> (!freeze && $past(freeze))); // R12
endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_1hz     (tick_1hz),
    .sel          (sel),
    .rd_en        (rd_en),
    .rdata        (rdata),
    .freeze       (freeze),
    .refresh_pend (refresh_pend),
    .load_pend    (load_pend),
    .wr_commit    (wr_commit),
    .usr_sec      (usr_sec),
    .cnt_sec      (cnt_sec),
    .cnt_min      (cnt_min)
);

// File: tb/test_rtc_timekeeper.sv
// Bench for rtc_timekeeper: a behavioural model stepped per rising edge,
// compared against rdata at every falling edge.
module test_rtc_timekeeper;
    typedef logic [7:0] tv_t [7];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 0;

    tv_t        m_usr, m_cnt;
    logic [7:0] m_ctrl;
    logic [6:0] m_dirty;
    logic       m_rpend, m_lpend, m_act;
    logic [3:0] m_addr;
    logic [7:0] m_data;

    localparam logic [7:0] FM [7] = '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h07, 8'h1F, 8'hFF};
    localparam logic [7:0] RV [7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    rtc_timekeeper i_rtc_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .sel(sel), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #2 clk = ~clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int fld(input logic [3:0] a);
        case (a)
            4'h0: return 0;
            4'h2: return 1;
            4'h4: return 2;
            4'h6: return 3;
            4'h8: return 4;
            4'h9: return 5;
            4'hA: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic tv_t adv(input tv_t t, input logic m24);
        tv_t r;
        int s, mi, h, d, w, mo, y;
        r  = t;
        s  = b2i(t[0]) + 1;
        mi = b2i(t[1]);
        d  = b2i(t[3]);
        w  = int'(t[4]);
        mo = b2i(t[5]);
        y  = b2i(t[6]);
        if (m24) h = b2i(t[2] & 8'h3F);
        else     h = (b2i(t[2] & 8'h3F) % 12) + (t[2][7] ? 12 : 0);
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        if (h == 24) begin h = 0; d++; w++; end
        if (w == 8) w = 1;
        if (d > mdays(mo, y)) begin d = 1; mo++; end
        if (mo == 13) begin mo = 1; y++; end
        if (y == 100) y = 0;
        r[0] = i2b(s);
        r[1] = i2b(mi);
        if (m24) r[2] = i2b(h);
        else     r[2] = {h >= 12, 7'(i2b((h % 12 == 0) ? 12 : h % 12))};
        r[3] = i2b(d);
        r[4] = 8'(w);
        r[5] = i2b(mo);
        r[6] = i2b(y);
        return r;
    endfunction

    function automatic logic [7:0] mread(input logic [3:0] a);
        if (a == 4'hE) return m_ctrl;
        if (fld(a) >= 0) return m_usr[fld(a)];
        return 8'h00;
    endfunction

    // Compare, then step the model to the state after the next rising edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_usr = RV; m_cnt = RV; m_ctrl = 8'h02; m_dirty = '0;
            m_rpend = 0; m_lpend = 0; m_act = 0; m_addr = '0; m_data = '0;
        end else if (!done) begin
            logic [7:0] ex;
            logic act, commit, n_lpend;
            tv_t n_usr, base;
            logic [7:0] n_ctrl;
            logic [6:0] n_dirty;
            int f;
            ex = (sel && rd_en) ? mread(addr) : 8'h00;
            vectors++;
            if (rdata !== ex) begin
                fails++;
                $display("FAIL %s: addr %h rdata %h expected %h", cur_req, addr, rdata, ex);
            end
            act     = sel && wr_en;
            commit  = m_act && !act;
            n_usr   = m_rpend ? m_cnt : m_usr;
            base    = m_cnt;
            for (int i = 0; i < 7; i++) if (m_lpend && m_dirty[i]) base[i] = m_usr[i];
            n_ctrl  = m_ctrl;
            n_dirty = m_lpend ? 7'd0 : m_dirty;
            n_lpend = 0;
            if (commit) begin
                f = fld(m_addr);
                if (f >= 0) begin
                    n_usr[f] = m_data & FM[f];
                    if (m_ctrl[3]) n_dirty[f] = 1'b1;
                end else if (m_addr == 4'hE) begin
                    n_ctrl  = m_data & 8'h0B;
                    n_lpend = m_ctrl[3] && !m_data[3];
                end
            end
            m_cnt   = tick_1hz ? adv(base, m_ctrl[1]) : base;
            m_rpend = tick_1hz && !m_ctrl[3];
            if (act) begin m_addr = addr; m_data = wdata; end
            m_act   = act;
            m_usr   = n_usr;
            m_ctrl  = n_ctrl;
            m_dirty = n_dirty;
            m_lpend = n_lpend;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1; sel = 1; wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1; sel = 0; wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(posedge clk); #1; sel = 1; rd_en = 1; addr = a;
        @(posedge clk); #1; sel = 0; rd_en = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1; tick_1hz = 1;
        @(posedge clk); #1; tick_1hz = 0;
    endtask

    task automatic read_all();
        foreach (RV[i]) rd(4'(fld_addr(i)));
        rd(4'hE);
        rd(4'hF);
    endtask

    function automatic int fld_addr(input int i);
        case (i)
            0: return 0; 1: return 2; 2: return 4; 3: return 6;
            4: return 8; 5: return 9; default: return 10;
        endcase
    endfunction

    task automatic set_time(input logic m24, input logic [7:0] s, input logic [7:0] mi,
                            input logic [7:0] h, input logic [7:0] d, input logic [7:0] w,
                            input logic [7:0] mo, input logic [7:0] y);
        wr(4'hE, {6'b000010 & {5'b0, m24, 2'b0} >> 1, 2'b00} | 8'h08 | (m24 ? 8'h02 : 8'h00));
        wr(4'h0, s); wr(4'h2, mi); wr(4'h4, h); wr(4'h6, d);
        wr(4'h8, w); wr(4'h9, mo); wr(4'hA, y);
        wr(4'hE, m24 ? 8'h02 : 8'h00);
        idle(2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1"; read_all();
        cur_req = "R2"; rd(4'h1); rd(4'h7); rd(4'hB);
        cur_req = "R3"; wr(4'h1, 8'hFF); rd(4'h1); wr(4'hF, 8'hAA); rd(4'hF);
        wr(4'hE, 8'h0A); wr(4'h8, 8'hFF); wr(4'h0, 8'hFF); rd(4'h8); rd(4'h0);
        wr(4'hE, 8'h02); idle(2);
        cur_req = "R4"; set_time(1, 8'h58, 8'h59, 8'h23, 8'h28, 8'h07, 8'h02, 8'h23);
        tick(); read_all();
        cur_req = "R5"; tick(); read_all();
        cur_req = "R7"; rd(4'h8);
        cur_req = "R8"; set_time(1, 8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h24);
        tick(); read_all(); tick(); tick(); read_all();
        set_time(1, 8'h59, 8'h59, 8'h23, 8'h29, 8'h04, 8'h02, 8'h24); tick(); read_all();
        set_time(1, 8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h04, 8'h00); tick(); read_all();
        set_time(1, 8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h05, 8'h00); tick(); read_all();
        cur_req = "R9"; set_time(1, 8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
        tick(); read_all();
        cur_req = "R6"; set_time(0, 8'h59, 8'h59, 8'h91, 8'h15, 8'h02, 8'h06, 8'h10);
        tick(); read_all();
        set_time(0, 8'h59, 8'h59, 8'h11, 8'h15, 8'h02, 8'h06, 8'h10); tick(); read_all();
        set_time(0, 8'h59, 8'h59, 8'h92, 8'h15, 8'h02, 8'h06, 8'h10); tick(); read_all();
        cur_req = "R10"; set_time(1, 8'h10, 8'h00, 8'h08, 8'h10, 8'h02, 8'h03, 8'h05);
        @(posedge clk); #1 tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0; sel = 1; rd_en = 1; addr = 4'h0;
        @(posedge clk); #1;
        @(posedge clk); #1 sel = 0; rd_en = 0;
        cur_req = "R11";
        @(posedge clk); #1 sel = 1; wr_en = 1; addr = 4'hE; wdata = 8'h0A;
        @(posedge clk); #1 sel = 0; wr_en = 0; tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0;
        read_all(); tick(); tick(); tick(); read_all();
        cur_req = "R12"; wr(4'h2, 8'h45); wr(4'hE, 8'h02); idle(2); read_all();
        tick(); read_all(); tick(); read_all();
        cur_req = "R13"; wr(4'h0, 8'h30); rd(4'h0); wr(4'h6, 8'h01); rd(4'h6);
        tick(); read_all();
        cur_req = "R14"; wr(4'hE, 8'h03); rd(4'hE); tick(); tick(); read_all();
        wr(4'hE, 8'hFF); rd(4'hE); tick(); read_all(); wr(4'hE, 8'h02); idle(2); read_all();
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule